// File: doc/BRIEF.md
# Interrupt Line Aggregator with Set/Clear Masking

This block merges 32 interrupt source lines into a single request for a parent interrupt controller. Software reaches it through a small 32-bit register bus. The bus has a write strobe, a byte address and a write word. Reads are combinational and follow the address. Each source has one bit in every register. The mask is never written as a whole word. A write-one-to-disable register sets mask bits, and a write-one-to-enable register clears them. A read-only mask view returns the current mask, where 1 means blocked.

A parameter picks one of two variants. The edge-latched variant records each rising edge of a source in a sticky pending bit. Software acknowledges a pending bit by writing 1 to it in an acknowledge register. A force register lets software set pending bits directly. The level variant shows the live source levels as its status and has no acknowledge register. In both variants the request output is high whenever a status bit is set and its mask bit is clear.

Register offsets, edge-latched variant: status 0x00, force 0x04, acknowledge 0x08, mask view 0x0C, disable 0x10, enable 0x14. Register offsets, level variant: status 0x00, mask view 0x04, disable 0x08, enable 0x0C.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all 32 mask bits read as 1, all latched pending bits read as 0, and `irqOut` is low.
- R2: A write of 1 to a bit of the disable register sets that mask bit. A 0 in the write word leaves that bit unchanged. Writing all ones masks every source.
- R3: A write of 1 to a bit of the enable register clears that mask bit. A 0 in the write word leaves that bit unchanged.
- R4: The mask view returns the current mask, with 1 meaning masked. It is at offset 0x0C in the edge-latched variant and at offset 0x04 in the level variant.
- R5: `irqOut` is high exactly when (status AND NOT mask) is nonzero. In the level variant it follows the inputs in the same cycle.
- R6: In the edge-latched variant, a 0-to-1 transition on a source line sets its pending bit at the next clock edge. The bit stays set after the line falls.
- R7: In the edge-latched variant, writing 1 to a bit of the acknowledge register (0x08) clears that pending bit. If a rising edge of the same source arrives in the same cycle as the acknowledge, the bit stays set.
- R8: In the edge-latched variant, writing 1 to a bit of the force register (0x04) sets that pending bit.
- R9: In the level variant, the status register (0x00) returns the live input levels and holds no history.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets, to the status register of the level variant, or to the mask view change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Interrupt source lines |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write word |
| rdData | output | 32 | Read word for `addr`, combinational |
| irqOut | output | 1 | Aggregated request to the parent |

## Verification
The assertions assume that a bus write lasts one clock cycle and hits a single offset. They also assume that source lines change only between clock edges, so the edge detector sees clean levels. The bench drives all inputs on the falling clock edge. It holds each write for exactly one cycle, and it keeps the sources low during reset so that no edge is seen while the block is held in reset. Sweeps walk every source bit through each variant with masks, edges and acknowledges. A separate pattern set covers pending bits forced by software and an edge that coincides with its acknowledge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Edge-latched variant register offsets
  localparam logic [7:0] LAT_STATUS = 8'h00;
  localparam logic [7:0] LAT_FORCE  = 8'h04;
  localparam logic [7:0] LAT_ACK    = 8'h08;
  localparam logic [7:0] LAT_MVIEW  = 8'h0C;
  localparam logic [7:0] LAT_MSET   = 8'h10;
  localparam logic [7:0] LAT_MCLR   = 8'h14;

  // Level variant register offsets
  localparam logic [7:0] LVL_STATUS = 8'h00;
  localparam logic [7:0] LVL_MVIEW  = 8'h04;
  localparam logic [7:0] LVL_MSET   = 8'h08;
  localparam logic [7:0] LVL_MCLR   = 8'h0C;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic ack;
    logic forceSet;
  } regStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK
  } rdSel_t;

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter bit LATCHED = 1'b1,
  parameter int ADDR_W  = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);

  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(LATCHED ? LAT_STATUS : LVL_STATUS);
  localparam logic [ADDR_W-1:0] OFF_MVIEW  = ADDR_W'(LATCHED ? LAT_MVIEW  : LVL_MVIEW);
  localparam logic [ADDR_W-1:0] OFF_MSET   = ADDR_W'(LATCHED ? LAT_MSET   : LVL_MSET);
  localparam logic [ADDR_W-1:0] OFF_MCLR   = ADDR_W'(LATCHED ? LAT_MCLR   : LVL_MCLR);
  localparam logic [ADDR_W-1:0] OFF_ACK    = ADDR_W'(LAT_ACK);
  localparam logic [ADDR_W-1:0] OFF_FORCE  = ADDR_W'(LAT_FORCE);

  always_comb begin
    strobe.maskSet  = wrEn && (addr == OFF_MSET);
    strobe.maskClr  = wrEn && (addr == OFF_MCLR);
    strobe.ack      = LATCHED && wrEn && (addr == OFF_ACK);
    strobe.forceSet = LATCHED && wrEn && (addr == OFF_FORCE);
  end

  always_comb begin
    if (addr == OFF_STATUS)     rdSel = RD_STATUS;
    else if (addr == OFF_MVIEW) rdSel = RD_MASK;
    else                        rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqagg_dp.sv
module irqagg_dp
  import irqagg_pkg::*;
#(
  parameter bit LATCHED = 1'b1,
  parameter int N       = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] srcIn,
  input  logic [N-1:0] wrData,
  input  regStrobe_t   strobe,
  input  rdSel_t       rdSel,
  output logic [N-1:0] rdData,
  output logic [N-1:0] statusWord,
  output logic [N-1:0] maskWord,
  output logic         irqOut
);

  logic [N-1:0] setBits;
  logic [N-1:0] clrBits;

  assign setBits = strobe.maskSet ? wrData : '0;
  assign clrBits = strobe.maskClr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) maskWord <= '1;
    else       maskWord <= (maskWord | setBits) & ~clrBits;
  end

  generate
    if (LATCHED) begin : g_latched
      logic [N-1:0] srcPrev;
      logic [N-1:0] pendReg;
      logic [N-1:0] riseBits;
      logic [N-1:0] ackBits;
      logic [N-1:0] frcBits;

      assign riseBits = srcIn & ~srcPrev;
      assign ackBits  = strobe.ack ? wrData : '0;
      assign frcBits  = strobe.forceSet ? wrData : '0;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          srcPrev <= '0;
          pendReg <= '0;
        end else begin
          srcPrev <= srcIn;
          // an edge or a force wins over an acknowledge in the same cycle
          pendReg <= (pendReg & ~ackBits) | riseBits | frcBits;
        end
      end

      assign statusWord = pendReg;
    end else begin : g_level
      assign statusWord = srcIn;
    end
  endgenerate

  assign irqOut = |(statusWord & ~maskWord);

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdData = statusWord;
      RD_MASK:   rdData = maskWord;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter bit LATCHED = 1'b1,
  parameter int N       = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      srcIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wrData,
  output logic [N-1:0]      rdData,
  output logic              irqOut
);

  regStrobe_t   strobe;
  rdSel_t       rdSel;
  logic [N-1:0] statusWord;
  logic [N-1:0] maskWord;

  irqagg_ctrl #(.LATCHED(LATCHED), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  irqagg_dp #(.LATCHED(LATCHED), .N(N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcIn      (srcIn),
    .wrData     (wrData),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .rdData     (rdData),
    .statusWord (statusWord),
    .maskWord   (maskWord),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter bit LATCHED = 1'b1,
  parameter int N       = 32,
  parameter int ADDR_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [N-1:0]      srcIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      wrData,
  input logic              irqOut,
  input logic [N-1:0]      statusWord,
  input logic [N-1:0]      maskWord
);

  localparam logic [ADDR_W-1:0] C_MSET = ADDR_W'(LATCHED ? LAT_MSET : LVL_MSET);
  localparam logic [ADDR_W-1:0] C_MCLR = ADDR_W'(LATCHED ? LAT_MCLR : LVL_MCLR);
  localparam logic [ADDR_W-1:0] C_ACK  = ADDR_W'(LAT_ACK);

  logic hitSet;
  logic hitClr;
  assign hitSet = wrEn && (addr == C_MSET);
  assign hitClr = wrEn && (addr == C_MCLR);

  AST_MASKSET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    hitSet |=> ((maskWord & $past(wrData)) == $past(wrData))); // R2

  AST_MASKCLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    hitClr |=> ((maskWord & $past(wrData)) == '0)); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(hitSet || hitClr) |=> $stable(maskWord)); // R10

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskWord == '1) |-> !irqOut); // R5

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusWord != '0)); // R5

  generate
    if (LATCHED) begin : g_lat
      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        !(wrEn && (addr == C_ACK)) |=> ((statusWord & $past(statusWord)) == $past(statusWord))); // R6

      AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
        ((srcIn & ~$past(srcIn)) != '0) |=> ((statusWord & $past(srcIn & ~$past(srcIn))) == $past(srcIn & ~$past(srcIn)))); // R6
    end else begin : g_lvl
      AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rstN)
        statusWord == srcIn); // R9
    end
  endgenerate

endmodule

bind irq_aggregator irqagg_checker #(.LATCHED(LATCHED), .N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcIn      (srcIn),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .irqOut     (irqOut),
  .statusWord (statusWord),
  .maskWord   (maskWord)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcL = '0;
  logic [31:0] srcV = '0;
  logic        wrL = 1'b0;
  logic        wrV = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdL;
  logic [31:0] rdV;
  logic        irqL;
  logic        irqV;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] expMaskL = '1;
  logic [31:0] expPendL = '0;
  logic [31:0] expMaskV = '1;

  always #5 clk = ~clk;

  irq_aggregator #(.LATCHED(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcL), .wrEn(wrL), .addr(addr),
    .wrData(wrData), .rdData(rdL), .irqOut(irqL)
  );

  irq_aggregator #(.LATCHED(1'b0)) u_dutLvl (
    .clk(clk), .rstN(rstN), .srcIn(srcV), .wrEn(wrV), .addr(addr),
    .wrData(wrData), .rdData(rdV), .irqOut(irqV)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input bit lvl, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    if (lvl) wrV = 1'b1; else wrL = 1'b1;
    @(negedge clk);
    wrL = 1'b0;
    wrV = 1'b0;
  endtask

  task automatic readCheck(input bit lvl, input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(req, lvl ? rdV : rdL, exp);
  endtask

  function automatic logic [31:0] irqExp(input logic [31:0] st, input logic [31:0] m);
    return {31'b0, |(st & ~m)};
  endfunction

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCheck(0, 8'h0C, 32'hFFFF_FFFF, "R1 latched mask");
    readCheck(0, 8'h00, 32'h0, "R1 latched pending");
    check("R1 latched irq", {31'b0, irqL}, 32'h0);
    readCheck(1, 8'h04, 32'hFFFF_FFFF, "R1 level mask");
    check("R1 level irq", {31'b0, irqV}, 32'h0);

    // R2 R3 R4: walk each mask bit in both variants
    for (int i = 0; i < 32; i++) begin
      busWrite(0, 8'h14, 32'h1 << i);
      expMaskL &= ~(32'h1 << i);
      readCheck(0, 8'h0C, expMaskL, "R3 R4 latched enable");
      busWrite(1, 8'h0C, 32'h1 << i);
      expMaskV &= ~(32'h1 << i);
      readCheck(1, 8'h04, expMaskV, "R3 R4 level enable");
    end
    for (int i = 0; i < 32; i += 3) begin
      busWrite(0, 8'h10, 32'h1 << i);
      expMaskL |= (32'h1 << i);
      readCheck(0, 8'h0C, expMaskL, "R2 latched disable");
      busWrite(1, 8'h08, 32'h1 << i);
      expMaskV |= (32'h1 << i);
      readCheck(1, 8'h04, expMaskV, "R2 level disable");
    end
    busWrite(0, 8'h10, 32'hFFFF_FFFF);
    expMaskL = '1;
    readCheck(0, 8'h0C, expMaskL, "R2 latched mask all");
    busWrite(1, 8'h08, 32'hFFFF_FFFF);
    expMaskV = '1;
    readCheck(1, 8'h04, expMaskV, "R2 level mask all");

    // R6 R5 R7: per-bit edge capture, unmask, acknowledge
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      srcL = 32'h1 << i;
      @(negedge clk);
      srcL = '0;
      expPendL = 32'h1 << i;
      @(negedge clk);
      readCheck(0, 8'h00, expPendL, "R6 edge latched and sticky");
      check("R5 masked pending gives no irq", {31'b0, irqL}, irqExp(expPendL, expMaskL));
      busWrite(0, 8'h14, 32'h1 << i);
      expMaskL &= ~(32'h1 << i);
      #1;
      check("R5 unmasked pending raises irq", {31'b0, irqL}, irqExp(expPendL, expMaskL));
      busWrite(0, 8'h08, 32'h1 << i);
      expPendL = '0;
      readCheck(0, 8'h00, expPendL, "R7 ack clears");
      check("R5 irq drops after ack", {31'b0, irqL}, 32'h0);
      busWrite(0, 8'h10, 32'h1 << i);
      expMaskL |= (32'h1 << i);
    end

    // R8 force, then partial acknowledge
    busWrite(0, 8'h04, 32'hA5A5_0F0F);
    expPendL = 32'hA5A5_0F0F;
    readCheck(0, 8'h00, expPendL, "R8 force sets pending");
    busWrite(0, 8'h08, 32'hFFFF_0000);
    expPendL &= ~32'hFFFF_0000;
    readCheck(0, 8'h00, expPendL, "R7 partial ack");
    busWrite(0, 8'h14, 32'h0000_00F0);
    expMaskL &= ~32'h0000_00F0;
    #1;
    check("R5 irq off when unmasked bits not pending", {31'b0, irqL}, irqExp(expPendL, expMaskL));
    busWrite(0, 8'h14, 32'h0000_0100);
    expMaskL &= ~32'h0000_0100;
    #1;
    check("R5 irq on unmasked pending", {31'b0, irqL}, irqExp(expPendL, expMaskL));
    busWrite(0, 8'h08, 32'hFFFF_FFFF);
    expPendL = '0;

    // R7 edge coincident with acknowledge keeps the bit
    busWrite(0, 8'h04, 32'h0000_0020);
    @(negedge clk);
    srcL = 32'h0000_0020;
    addr = 8'h08;
    wrData = 32'h0000_0020;
    wrL = 1'b1;
    @(negedge clk);
    wrL = 1'b0;
    srcL = '0;
    readCheck(0, 8'h00, 32'h0000_0020, "R7 edge beats ack");
    busWrite(0, 8'h08, 32'h0000_0020);
    readCheck(0, 8'h00, 32'h0, "R7 later ack clears");

    // R10 latched: status and mask view are read-only, unmapped reads zero
    busWrite(0, 8'h00, 32'hFFFF_FFFF);
    readCheck(0, 8'h00, 32'h0, "R10 status write ignored");
    busWrite(0, 8'h0C, 32'hFFFF_FFFF);
    readCheck(0, 8'h0C, expMaskL, "R10 mask view write ignored");
    busWrite(0, 8'h1C, 32'hFFFF_FFFF);
    readCheck(0, 8'h1C, 32'h0, "R10 unmapped read zero");
    readCheck(0, 8'h0C, expMaskL, "R10 unmapped write ignored");

    // R9 R5 level: per-bit live status, no history
    busWrite(1, 8'h0C, 32'hFFFF_FFFF);
    expMaskV = '0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      srcV = 32'h1 << i;
      readCheck(1, 8'h00, srcV, "R9 live level");
      check("R5 level irq follows input", {31'b0, irqV}, irqExp(srcV, expMaskV));
      srcV = '0;
      readCheck(1, 8'h00, 32'h0, "R9 no history");
      check("R5 level irq drops", {31'b0, irqV}, 32'h0);
    end

    // R5 level pattern set against several masks
    for (int p = 0; p < 6; p++) begin
      logic [31:0] pat;
      logic [31:0] mpat;
      pat  = 32'h1357_9BDF * (p + 1);
      mpat = ~(32'h0F0F_0F0F << p);
      busWrite(1, 8'h08, 32'hFFFF_FFFF);
      busWrite(1, 8'h0C, ~mpat);
      expMaskV = mpat;
      srcV = pat;
      readCheck(1, 8'h00, pat, "R9 level pattern");
      check("R5 level pattern irq", {31'b0, irqV}, irqExp(pat, expMaskV));
      srcV = pat & mpat;
      #1;
      check("R5 level masked pattern irq", {31'b0, irqV}, irqExp(srcV, expMaskV));
    end
    srcV = '0;

    // R10 level: latched-only offsets and the mask view change nothing
    busWrite(1, 8'h10, 32'hFFFF_FFFF);
    readCheck(1, 8'h04, expMaskV, "R10 level 0x10 ignored");
    busWrite(1, 8'h14, 32'hFFFF_FFFF);
    readCheck(1, 8'h04, expMaskV, "R10 level 0x14 ignored");
    busWrite(1, 8'h04, ~expMaskV);
    readCheck(1, 8'h04, expMaskV, "R10 level mask view read-only");
    busWrite(1, 8'h00, 32'hFFFF_FFFF);
    readCheck(1, 8'h04, expMaskV, "R10 level status write ignored");
    readCheck(1, 8'h10, 32'h0, "R10 level unmapped read zero");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule